// File: doc/BRIEF.md
# Raster line cursor overlay

This block draws programmable cursor lines on top of a live video stream. A host fills a byte-wide control register bank, presented to the block as one flat vector, with pixel and line coordinates. The block compares those coordinates against the raster position it is given and raises one trigger wire per coordinate. The triggers are then folded into the outgoing colour.

There are 48 coordinates in the default build. Each even-numbered trigger marks a pixel column and draws a vertical line one pixel wide. Each odd-numbered trigger marks a scan line and draws a horizontal bar across the whole line. The two triggers of each pair share one colour. That colour is forced onto the upper bits of the red, green and blue channels of the incoming 12-bit pixel.

The 96-byte coordinate window can sit at any even byte offset in the bank, chosen by a parameter. The sync generator that supplies the counters and strobes lies outside this block. It places the visible picture 16 pixels right and 16 lines down from counter zero, so coordinates 0 to 15 fall outside the visible area. The block itself treats them like any other value.

Top module: `raster_cursor_overlay`

## Requirements
- R1: A synchronous active-high reset clears every trigger and the pixel output to zero on the next clock edge.
- R2: On a clock edge where pix_en is high, even trigger 2k loads the result of comparing h_pos with its coordinate. It therefore goes high for one pixel period, one clock after h_pos equals the coordinate.
- R3: The coordinate of trigger t comes from two bank bytes. Byte BASE_OFS+2t supplies coordinate bits [9:8] in its bits [1:0], and its bits [7:2] are ignored. Byte BASE_OFS+2t+1 supplies coordinate bits [7:0]. Byte n of the bank occupies reg_bank[8n+7:8n].
- R4: Odd trigger 2k+1 is reloaded only on an edge where pix_en and line_start are both high, with the result of comparing v_pos with its coordinate. It holds that value across the whole scan line.
- R5: On an edge where pix_en is low, every trigger keeps its value, and a line_start pulse on such a cycle has no effect.
- R6: The BASE_OFS parameter moves the whole 96-byte coordinate window within the bank.
- R7: pix_out is pix_in registered once. It is bit-for-bit equal to pix_in of the previous cycle whenever no trigger of the next state is set, so a cursor pixel lines up with its coordinate.
- R8: Pair k (triggers 2k and 2k+1) is active when either trigger's next state is high, and then uses colour j = k mod 8. For j = 0 the colour is red, green and blue together. For any other j, bit 2 of j selects red, bit 1 selects green and bit 0 selects blue. A selected channel gets its two most significant bits forced to one. The channels sit at pix_out[11:8] for red, [7:4] for green and [3:0] for blue.
- R9: A coordinate that the counters never reach, for example 1023, never raises its trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel-enable strobe; evaluation happens only when high |
| line_start | input | 1 | Line boundary strobe, high together with the first pixel of each line |
| h_pos | input | 10 | Horizontal pixel counter |
| v_pos | input | 10 | Vertical line counter |
| reg_bank | input | 2048 | Control register bank, byte n at bits [8n+7:8n] |
| pix_in | input | 12 | Incoming colour {R,G,B}, 4 bits each |
| trig | output | 48 | Trigger bus; even bits mark columns, odd bits mark lines |
| pix_out | output | 12 | Colour with the cursor overlay applied |

## Verification
Both the trigger bus and the mixed pixel are due one clock edge after the inputs that cause them. The bench drives the inputs on a falling edge and samples both outputs on the next falling edge. It first advances its own arithmetic model by exactly one step for the inputs it just applied, then compares. Every such cycle is checked, including cycles where pix_en is low and cycles where line_start arrives without pix_en, so a trigger that responds a cycle early or late, or that fails to hold, shows up at once. A second instance with a relocated window is checked in the same way from the same bank.

// File: rtl/raster_ovl_pkg.sv
package raster_ovl_pkg;

  typedef struct packed {
    logic red;
    logic grn;
    logic blu;
  } rgb_sel_t;

  // colour chosen for cursor pair k: slot 0 is white, other slots use their bits
  function automatic rgb_sel_t pair_rgb(input int k);
    logic [2:0] slot;
    rgb_sel_t   s;
    slot = 3'(k % 8);
    if (slot == 3'd0) s = '{red: 1'b1, grn: 1'b1, blu: 1'b1};
    else              s = '{red: slot[2], grn: slot[1], blu: slot[0]};
    return s;
  endfunction

endpackage

// File: rtl/rc_coord_window.sv
module rc_coord_window #(
  parameter int N_TRIG     = 48,
  parameter int BANK_BYTES = 256,
  parameter int BASE_OFS   = 32,
  parameter int CNT_W      = 10
) (
  input  logic [BANK_BYTES*8-1:0]   bank,
  output logic [N_TRIG*CNT_W-1:0]   coords
);
  localparam int HI_BITS = CNT_W - 8;

  for (genvar t = 0; t < N_TRIG; t++) begin : g_coord
    localparam int HI_BYTE = BASE_OFS + 2*t;
    localparam int LO_BYTE = BASE_OFS + 2*t + 1;
    assign coords[t*CNT_W +: CNT_W] = {bank[HI_BYTE*8 +: HI_BITS], bank[LO_BYTE*8 +: 8]};
  end
endmodule

// File: rtl/rc_trig_cell.sv
module rc_trig_cell #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] coord,
  output logic             trig_d,
  output logic             trig_q
);
  always_comb trig_d = upd ? (cnt == coord) : trig_q;

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= trig_d;
  end
endmodule

// File: rtl/rc_mixer.sv
module rc_mixer
  import raster_ovl_pkg::*;
#(
  parameter int N_TRIG   = 48,
  parameter int CHAN_W   = 4,
  parameter int OVL_BITS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_TRIG-1:0]     trig_d,
  input  logic [3*CHAN_W-1:0]   pix_in,
  output logic [3*CHAN_W-1:0]   pix_out
);
  localparam int N_PAIR = N_TRIG / 2;
  localparam int PIX_W  = 3 * CHAN_W;

  logic [PIX_W-1:0] ovl;

  always_comb begin
    ovl = '0;
    for (int k = 0; k < N_PAIR; k++) begin
      if (trig_d[2*k] || trig_d[2*k+1]) begin
        if (pair_rgb(k).red) ovl[3*CHAN_W-1 -: OVL_BITS] = {OVL_BITS{1'b1}};
        if (pair_rgb(k).grn) ovl[2*CHAN_W-1 -: OVL_BITS] = {OVL_BITS{1'b1}};
        if (pair_rgb(k).blu) ovl[CHAN_W-1   -: OVL_BITS] = {OVL_BITS{1'b1}};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pix_out <= '0;
    else     pix_out <= pix_in | ovl;
  end
endmodule

// File: rtl/raster_cursor_overlay.sv
module raster_cursor_overlay #(
  parameter int N_TRIG     = 48,
  parameter int CNT_W      = 10,
  parameter int BANK_BYTES = 256,
  parameter int BASE_OFS   = 32,
  parameter int CHAN_W     = 4,
  parameter int OVL_BITS   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pix_en,
  input  logic                    line_start,
  input  logic [CNT_W-1:0]        h_pos,
  input  logic [CNT_W-1:0]        v_pos,
  input  logic [BANK_BYTES*8-1:0] reg_bank,
  input  logic [3*CHAN_W-1:0]     pix_in,
  output logic [N_TRIG-1:0]       trig,
  output logic [3*CHAN_W-1:0]     pix_out
);
  logic [N_TRIG*CNT_W-1:0] coords;
  logic [N_TRIG-1:0]       trig_d;
  logic                    row_upd;

  assign row_upd = pix_en & line_start;

  rc_coord_window #(
    .N_TRIG(N_TRIG), .BANK_BYTES(BANK_BYTES), .BASE_OFS(BASE_OFS), .CNT_W(CNT_W)
  ) u_win (
    .bank(reg_bank), .coords(coords)
  );

  for (genvar t = 0; t < N_TRIG; t++) begin : g_cell
    if (t % 2 == 0) begin : g_col
      rc_trig_cell #(.CNT_W(CNT_W)) u_cell (
        .clk(clk), .rst(rst), .upd(pix_en), .cnt(h_pos),
        .coord(coords[t*CNT_W +: CNT_W]), .trig_d(trig_d[t]), .trig_q(trig[t])
      );
    end else begin : g_row
      rc_trig_cell #(.CNT_W(CNT_W)) u_cell (
        .clk(clk), .rst(rst), .upd(row_upd), .cnt(v_pos),
        .coord(coords[t*CNT_W +: CNT_W]), .trig_d(trig_d[t]), .trig_q(trig[t])
      );
    end
  end

  rc_mixer #(.N_TRIG(N_TRIG), .CHAN_W(CHAN_W), .OVL_BITS(OVL_BITS)) u_mix (
    .clk(clk), .rst(rst), .trig_d(trig_d), .pix_in(pix_in), .pix_out(pix_out)
  );
endmodule

// File: rtl/raster_cursor_overlay_chk.sv
module raster_cursor_overlay_chk #(
  parameter int N_TRIG = 48,
  parameter int CHAN_W = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  pix_en,
  input logic                  line_start,
  input logic [3*CHAN_W-1:0]   pix_in,
  input logic [N_TRIG-1:0]     trig,
  input logic [3*CHAN_W-1:0]   pix_out
);
  function automatic logic [N_TRIG-1:0] odd_lanes();
    logic [N_TRIG-1:0] m;
    m = '0;
    for (int i = 1; i < N_TRIG; i += 2) m[i] = 1'b1;
    return m;
  endfunction
  localparam logic [N_TRIG-1:0] ODD_MASK = odd_lanes();

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (trig == '0 && pix_out == '0));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> $stable(trig));

  assert_row_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (pix_en && !line_start) |=> $stable(trig & ODD_MASK));

  assert_passthru_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && trig == '0) |-> pix_out == $past(pix_in));

  assert_keep_input_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pix_out & $past(pix_in)) == $past(pix_in)));
endmodule

bind raster_cursor_overlay raster_cursor_overlay_chk #(.N_TRIG(N_TRIG), .CHAN_W(CHAN_W)) u_chk (
  .clk(clk), .rst(rst), .pix_en(pix_en), .line_start(line_start),
  .pix_in(pix_in), .trig(trig), .pix_out(pix_out)
);

// File: tb/sim_raster_cursor_overlay.sv
`timescale 1ns/1ps
module sim_raster_cursor_overlay;
  localparam int N     = 48;
  localparam int BANK  = 256;
  localparam int BASE0 = 32;
  localparam int BASE1 = 100;
  localparam int H_TOT = 264;
  localparam int V_LO  = 250;
  localparam int V_HI  = 261;
  localparam int NCYC  = 15000;
  localparam int RST_AT = 9000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_en = 1'b0, line_start = 1'b0;
  logic [9:0] h_pos = '0, v_pos = '0;
  logic [BANK*8-1:0] bank;
  logic [11:0] pix_in = '0;
  logic [N-1:0] trig0, trig1;
  logic [11:0]  pix0, pix1;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  raster_cursor_overlay u0 (
    .clk(clk), .rst(rst), .pix_en(pix_en), .line_start(line_start), .h_pos(h_pos),
    .v_pos(v_pos), .reg_bank(bank), .pix_in(pix_in), .trig(trig0), .pix_out(pix0));

  raster_cursor_overlay #(.BASE_OFS(BASE1)) u1 (
    .clk(clk), .rst(rst), .pix_en(pix_en), .line_start(line_start), .h_pos(h_pos),
    .v_pos(v_pos), .reg_bank(bank), .pix_in(pix_in), .trig(trig1), .pix_out(pix1));

  task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_coord(input int base, input int t, input int val);
    bank[(base+2*t)*8 +: 8]   = 8'hA8 | 8'(val >> 8);   // R3: upper six bits are junk
    bank[(base+2*t+1)*8 +: 8] = 8'(val & 8'hFF);
  endtask

  function automatic int coord_of(input int base, input int t);
    return ((int'(bank[(base+2*t)*8 +: 8]) & 3) << 8) | int'(bank[(base+2*t+1)*8 +: 8]);
  endfunction

  // R8 colour table computed from the stated rule
  function automatic logic [11:0] colour_mask(input logic [N-1:0] tv);
    logic [11:0] m = '0;
    for (int k = 0; k < N/2; k++) begin
      if (tv[2*k] | tv[2*k+1]) begin
        int j = k % 8;
        if (j == 0 || (j & 4) != 0) m |= 12'hC00;
        if (j == 0 || (j & 2) != 0) m |= 12'h0C0;
        if (j == 0 || (j & 1) != 0) m |= 12'h00C;
      end
    end
    return m;
  endfunction

  function automatic logic [N-1:0] step_model(input logic [N-1:0] cur, input int base,
      input bit en, input bit ls, input int h, input int v);
    logic [N-1:0] nx = cur;
    for (int t = 0; t < N; t++) begin
      if (t % 2 == 0) begin
        if (en) nx[t] = (h == coord_of(base, t));
      end else begin
        if (en && ls) nx[t] = (v == coord_of(base, t));
      end
    end
    return nx;
  endfunction

  function automatic bit en_pattern(input int n);
    case ((n / 2000) % 3)
      0: return 1'b1;
      1: return (n % 2) == 0;
      default: return ((n * 7) % 5) != 0;
    endcase
  endfunction

  localparam logic [N-1:0] EVEN = {(N/2){2'b01}};
  localparam logic [N-1:0] ODD  = {(N/2){2'b10}};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] e0, e1, seen0, seen1;
    logic [11:0]  ep0, ep1;
    int h, v;
    bank = '1;
    set_coord(BASE0, 0, 5);     set_coord(BASE0, 1, 252);
    set_coord(BASE0, 2, 257);   set_coord(BASE0, 3, 258);
    set_coord(BASE0, 4, 5);     set_coord(BASE0, 10, 263);
    set_coord(BASE0, 15, 250);  set_coord(BASE0, 46, 130);
    set_coord(BASE0, 47, 255);  set_coord(BASE0, 8, 300);
    set_coord(BASE0, 9, 262);   set_coord(BASE0, 20, 0);
    set_coord(BASE1, 14, 77);   set_coord(BASE1, 21, 259);
    e0 = '0; e1 = '0; seen0 = '0; seen1 = '0;
    h = 0; v = V_LO;
    repeat (3) @(negedge clk);
    chk(trig0 == '0 && trig1 == '0, "R1 trig after reset", trig0, '0);
    chk(pix0 == '0 && pix1 == '0, "R1 pix_out after reset", N'(pix0), '0);

    for (int n = 0; n < NCYC; n++) begin
      bit en, ls, r;
      logic [11:0] pin;
      r   = (n == RST_AT || n == RST_AT + 1);
      en  = en_pattern(n);
      ls  = (h == 0);
      pin = 12'((n * 37 + (n >> 3)) & 12'hFFF);
      rst = r; pix_en = en; line_start = ls;
      h_pos = 10'(h); v_pos = 10'(v); pix_in = pin;
      @(negedge clk);
      if (r) begin
        e0 = '0; e1 = '0; ep0 = '0; ep1 = '0;
        chk(trig0 == '0 && trig1 == '0, "R1 trig during reset", trig0, '0);
        chk(pix0 == '0, "R1 pix_out during reset", N'(pix0), '0);
      end else begin
        e0 = step_model(e0, BASE0, en, ls, h, v);
        e1 = step_model(e1, BASE1, en, ls, h, v);
        ep0 = pin | colour_mask(e0);
        ep1 = pin | colour_mask(e1);
        chk(((trig0 ^ e0) & EVEN) == '0, en ? "R2 column triggers" : "R5 hold columns", trig0, e0);
        chk(((trig0 ^ e0) & ODD) == '0, en ? "R4 row triggers" : "R5 hold rows", trig0, e0);
        chk(trig1 == e1, "R6 relocated window triggers", trig1, e1);
        chk(pix0 == ep0, "R7 R8 mixed pixel", N'(pix0), N'(ep0));
        chk(pix1 == ep1, "R6 R8 mixed pixel relocated", N'(pix1), N'(ep1));
        seen0 |= trig0; seen1 |= trig1;
      end
      if (en) begin
        h++;
        if (h == H_TOT) begin
          h = 0; v++;
          if (v > V_HI) v = V_LO;
        end
      end
    end

    chk(seen0[2] && seen0[3], "R3 high coordinate bits decoded", seen0, 48'hC);
    chk(!seen0[8] && !seen0[9], "R9 unreachable coordinates stay low", seen0, '0);
    chk(!seen0[6] && !seen0[7], "R9 coordinate 1023 never fires", seen0, '0);
    chk(!seen0[14] && seen1[14], "R6 window offset selects other bytes", seen1, 48'h4000);
    chk(seen0[20] && seen0[15], "R2 R4 boundary coordinates fire", seen0, 48'h108000);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule